// File: doc/BRIEF.md
# Regulator Soft-Start Sequencer

This block sequences the start-up of a multiphase PWM buck regulator. It counts switching-cycle ticks from a clean start. The count selects four things: whether the reference DAC is held off, how every phase output is driven, the ceiling on PWM pulse width, and when power-good may be reported.

A start begins with all phase outputs floating and the DAC held off. A programmable interval follows in which the outputs are held low, so the lower switches stay on. After that the outputs run, and the duty ceiling climbs from zero to full scale one step per tick. Power-good rises only after a fixed total tick count, whatever the output voltage did before then.

Dropping the supply-ready input, or flagging overcurrent, throws the sequence back to its first cycle. The analog loop is not part of this block: the error amplifier, sawtooth, comparators and gate drivers stay outside. They consume the mode and ceiling outputs.

Top module: `softstart_seq`

## Requirements
- R1: While reset (`rst_n` low) is applied and right after it, every phase reads mode code 2'b00 (high impedance), `dac_inhibit` is 1, `duty_max` is 0 and `pgood` is 0.
- R2: For the first HIZ_CYC accepted ticks (default 32) of a start, every phase mode is 2'b00 and `dac_inhibit` is 1; `dac_inhibit` is 0 in every later stage.
- R3: For the next LOW_CYC accepted ticks (default 150), every phase mode is 2'b01 (forced low).
- R4: After that, every phase mode is 2'b10 (active). `duty_max` is 0 on the first active cycle and grows by DUTY_STEP on each later accepted tick. It is 0 in every non-active stage.
- R5: `duty_max` saturates at its all-ones code (2**DUTY_W-1) and stays there.
- R6: `pgood` becomes 1 on the edge that accepts the PG_CYC-th tick (default 2048) and stays 1 until a restart.
- R7: With `supply_ok` low at a clock edge, the block returns to its start state on that edge (as in R1) and holds it while `supply_ok` stays low.
- R8: With `ovc` high at a clock edge, the block restarts the same way, also after `pgood` is set, and holds its start state while `ovc` stays high.
- R9: A clock edge with `tick` low changes no output.
- R10: All phases carry the same mode; phase i occupies bits [2i+1:2i] of `phase_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse per switching cycle |
| supply_ok | input | 1 | Controller supply is above its threshold |
| ovc | input | 1 | Overcurrent detected |
| dac_inhibit | output | 1 | Holds the reference DAC off |
| phase_mode | output | 2*PHASES | Per-phase drive mode: 00 float, 01 low, 10 active |
| duty_max | output | DUTY_W | PWM duty ceiling code |
| pgood | output | 1 | Power-good |

## Verification
Every output comes from state that updates on the clock edge accepting a tick, a supply loss or an overcurrent. Each result is therefore due exactly one edge after the input that causes it. The bench drives inputs on the falling edge and moves its behavioural model by one step at the same moment. It then compares every output at the next falling edge, so model and design are always one rising edge past the same stimulus. Stage boundaries (tick 32, tick 182, duty saturation, tick 2048) are hit with ticks spaced one and three cycles apart. The spaced case makes the no-tick hold of R9 visible between ticks.

// File: rtl/softstart_pkg.sv
package softstart_pkg;
   typedef enum logic [1:0] {
      MODE_HIZ = 2'b00,
      MODE_LOW = 2'b01,
      MODE_RUN = 2'b10
   } drv_mode_e;
endpackage

// File: rtl/softstart_cnt.sv
// Saturating tick counter with registered completion flag.
module softstart_cnt #(
   parameter int LIMIT = 2048,
   parameter int W     = $clog2(LIMIT + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         adv,
   output logic [W-1:0] cnt,
   output logic         done
);
   localparam logic [W-1:0] LIM_V  = W'(LIMIT);
   localparam logic [W-1:0] LAST_V = W'(LIMIT - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         done <= 1'b0;
      end else if (clr) begin
         cnt  <= '0;
         done <= 1'b0;
      end else if (adv && cnt != LIM_V) begin
         cnt <= cnt + 1'b1;
         if (cnt == LAST_V) done <= 1'b1;
      end
   end
endmodule

// File: rtl/softstart_stage.sv
// Decodes the tick count into a drive stage and fans it out per phase.
module softstart_stage
   import softstart_pkg::*;
#(
   parameter int PHASES  = 4,
   parameter int HIZ_CYC = 32,
   parameter int LOW_CYC = 150,
   parameter int W       = 12
) (
   input  logic [W-1:0]          cnt,
   output logic                  dac_off,
   output logic                  running,
   output logic [2*PHASES-1:0]   modes
);
   localparam logic [W-1:0] LOW_AT = W'(HIZ_CYC);
   localparam logic [W-1:0] RUN_AT = W'(HIZ_CYC + LOW_CYC);

   drv_mode_e stage;

   always_comb begin
      if (cnt < LOW_AT)      stage = MODE_HIZ;
      else if (cnt < RUN_AT) stage = MODE_LOW;
      else                   stage = MODE_RUN;
   end

   assign dac_off = (stage == MODE_HIZ);
   assign running = (stage == MODE_RUN);

   for (genvar p = 0; p < PHASES; p++) begin : g_phase
      assign modes[2*p +: 2] = stage;
   end
endmodule

// File: rtl/softstart_ramp.sv
// Duty-ceiling ramp: zero after clear, one step per advance, saturating.
module softstart_ramp #(
   parameter int DUTY_W    = 8,
   parameter int DUTY_STEP = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              adv,
   output logic [DUTY_W-1:0] duty
);
   localparam logic [DUTY_W-1:0] TOP = '1;
   logic [DUTY_W-1:0] nxt;

   if (DUTY_STEP == 1) begin : g_unit
      assign nxt = (duty == TOP) ? TOP : duty + 1'b1;
   end else begin : g_wide
      localparam logic [DUTY_W:0] STEP_V = (DUTY_W + 1)'(DUTY_STEP);
      logic [DUTY_W:0] sum;
      assign sum = {1'b0, duty} + STEP_V;
      assign nxt = (sum > {1'b0, TOP}) ? TOP : sum[DUTY_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   duty <= '0;
      else if (clr) duty <= '0;
      else if (adv) duty <= nxt;
   end
endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
   import softstart_pkg::*;
#(
   parameter int PHASES    = 4,
   parameter int HIZ_CYC   = 32,
   parameter int LOW_CYC   = 150,
   parameter int PG_CYC    = 2048,
   parameter int DUTY_W    = 8,
   parameter int DUTY_STEP = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                supply_ok,
   input  logic                ovc,
   output logic                dac_inhibit,
   output logic [2*PHASES-1:0] phase_mode,
   output logic [DUTY_W-1:0]   duty_max,
   output logic                pgood
);
   localparam int CNT_W = $clog2(PG_CYC + 1);

   initial begin
      if (PHASES < 1) $fatal(1, "PHASES must be at least 1");
      if (HIZ_CYC < 1 || LOW_CYC < 1) $fatal(1, "stage lengths must be positive");
      if (PG_CYC <= HIZ_CYC + LOW_CYC) $fatal(1, "PG_CYC must exceed the float and low stages");
      if (DUTY_W < 1 || DUTY_STEP < 1) $fatal(1, "duty ramp parameters must be positive");
   end

   logic             restart;
   logic             step;
   logic             running;
   logic [CNT_W-1:0] cyc;

   assign restart = !supply_ok || ovc;
   assign step    = tick && !restart;

   softstart_cnt #(.LIMIT(PG_CYC), .W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (restart),
      .adv  (step),
      .cnt  (cyc),
      .done (pgood)
   );

   softstart_stage #(
      .PHASES (PHASES),
      .HIZ_CYC(HIZ_CYC),
      .LOW_CYC(LOW_CYC),
      .W      (CNT_W)
   ) u_stage (
      .cnt    (cyc),
      .dac_off(dac_inhibit),
      .running(running),
      .modes  (phase_mode)
   );

   softstart_ramp #(.DUTY_W(DUTY_W), .DUTY_STEP(DUTY_STEP)) u_ramp (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (restart),
      .adv  (step && running),
      .duty (duty_max)
   );
endmodule

// File: rtl/softstart_seq_chk.sv
module softstart_seq_chk
   import softstart_pkg::*;
#(
   parameter int PHASES = 4,
   parameter int DUTY_W = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                tick,
   input logic                supply_ok,
   input logic                ovc,
   input logic                dac_inhibit,
   input logic [2*PHASES-1:0] phase_mode,
   input logic [DUTY_W-1:0]   duty_max,
   input logic                pgood
);
   logic [1:0] m0;
   assign m0 = phase_mode[1:0];

   p_same_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
      phase_mode == {PHASES{m0}});

   p_dac_float_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dac_inhibit == (m0 == MODE_HIZ));

   p_duty_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (m0 != MODE_RUN) |-> (duty_max == '0));

   p_duty_rises_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (supply_ok && !ovc) |=> (duty_max >= $past(duty_max)));

   p_pg_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pgood |-> (m0 == MODE_RUN));

   p_pg_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pgood && supply_ok && !ovc) |=> pgood);

   p_supply_loss_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |=> (!pgood && dac_inhibit && duty_max == '0));

   p_overcurrent_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ovc |=> (!pgood && dac_inhibit && duty_max == '0));

   p_no_tick_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && supply_ok && !ovc) |=>
         ($stable(duty_max) && $stable(phase_mode) && $stable(pgood) && $stable(dac_inhibit)));
endmodule

bind softstart_seq softstart_seq_chk #(.PHASES(PHASES), .DUTY_W(DUTY_W)) u_chk (.*);

// File: tb/tb_softstart_seq.sv
`timescale 1ns/1ps
module tb_softstart_seq;
   localparam int PHASES = 4;
   localparam int HIZ    = 32;
   localparam int LOW    = 150;
   localparam int PG     = 2048;
   localparam int DW     = 8;
   localparam int STEP   = 1;
   localparam int DMAX   = (1 << DW) - 1;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                tick = 1'b0;
   logic                supply_ok = 1'b0;
   logic                ovc = 1'b0;
   logic                dac_inhibit;
   logic [2*PHASES-1:0] phase_mode;
   logic [DW-1:0]       duty_max;
   logic                pgood;

   int vectors = 0;
   int errors  = 0;
   bit done    = 0;

   int m_cnt = 0, m_duty = 0, m_pg = 0;

   always #2 clk = ~clk;

   softstart_seq dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok), .ovc(ovc),
      .dac_inhibit(dac_inhibit), .phase_mode(phase_mode), .duty_max(duty_max), .pgood(pgood)
   );

   function automatic int stage_of(int c);
      if (c < HIZ) return 0;
      if (c < HIZ + LOW) return 1;
      return 2;
   endfunction

   function automatic string stage_req(int c);
      if (c < HIZ) return "R2";
      if (c < HIZ + LOW) return "R3";
      return "R4";
   endfunction

   task automatic chk(string req, int act, int exp);
      vectors++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      int st = stage_of(m_cnt);
      logic [2*PHASES-1:0] em = {PHASES{2'(st)}};
      chk(stage_req(m_cnt), int'(phase_mode), int'(em));
      chk("R2 dac", int'(dac_inhibit), (st == 0) ? 1 : 0);
      chk((m_duty == DMAX) ? "R5" : "R4", int'(duty_max), m_duty);
      chk("R6", int'(pgood), m_pg);
      chk("R10", int'(phase_mode), int'({PHASES{phase_mode[1:0]}}));
   endtask

   // drive now (falling edge), advance the model, compare at the next falling edge
   task automatic step(bit sok, bit oc, bit tk);
      supply_ok = sok; ovc = oc; tick = tk;
      if (!rst_n || !sok || oc) begin
         m_cnt = 0; m_duty = 0; m_pg = 0;
      end else if (tk) begin
         if (stage_of(m_cnt) == 2) m_duty = (m_duty + STEP > DMAX) ? DMAX : m_duty + STEP;
         if (m_cnt < PG) begin
            m_cnt++;
            if (m_cnt == PG) m_pg = 1;
         end
      end
      @(negedge clk);
      compare_all();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] hold_d;
      logic [2*PHASES-1:0] hold_m;
      @(negedge clk);
      step(1, 0, 1);
      step(1, 0, 1);
      // R1: start state under reset
      chk("R1 mode", int'(phase_mode), 0);
      chk("R1 dac", int'(dac_inhibit), 1);
      chk("R1 duty", int'(duty_max), 0);
      chk("R1 pgood", int'(pgood), 0);
      rst_n = 1'b1;
      step(1, 0, 0);
      chk("R1 after release", int'(phase_mode), 0);

      // full start with a tick every third cycle
      for (int i = 0; i < 3 * (PG + 20); i++) begin
         step(1, 0, (i % 3) == 0);
         if (i == 3 * 300 + 1) begin
            hold_d = duty_max; hold_m = phase_mode;
            step(1, 0, 0);
            chk("R9 duty hold", int'(duty_max), int'(hold_d));
            chk("R9 mode hold", int'(phase_mode), int'(hold_m));
         end
      end
      chk("R6 pgood set", int'(pgood), 1);
      chk("R5 saturated", int'(duty_max), DMAX);

      // supply loss after power-good
      step(0, 0, 1);
      chk("R7 pgood", int'(pgood), 0);
      chk("R7 dac", int'(dac_inhibit), 1);
      chk("R7 duty", int'(duty_max), 0);
      step(0, 0, 1);
      chk("R7 held", int'(phase_mode), 0);

      // tick every cycle into the ramp, then an overcurrent pulse
      for (int i = 0; i < 400; i++) step(1, 0, 1);
      step(1, 1, 1);
      chk("R8 restart mode", int'(phase_mode), 0);
      chk("R8 restart duty", int'(duty_max), 0);
      for (int i = 0; i < 5; i++) step(1, 1, 1);
      chk("R8 held", int'(dac_inhibit), 1);
      for (int i = 0; i < PG + 5; i++) step(1, 0, 1);
      chk("R6 pgood again", int'(pgood), 1);
      step(1, 1, 0);
      chk("R8 after pgood", int'(pgood), 0);
      step(1, 0, 1);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule